// File: doc/BRIEF.md
# Burst Address Sequencer with Reload

This block produces the access address for one port of a synchronous, banked memory. In every clock cycle it chooses the address from one of three sources. The first is an external address that an active-low strobe captures. The second is its own counter, which either steps forward under an active-low step enable or stays where it is. The third is a saved reload address, selected by an active-low reload input. The counter is one field made of a bank number above an in-bank offset. A burst therefore runs from the last word of one bank into the first word of the next, and from the last bank back to bank zero.

The address it chooses leaves the block at once, together with a write strobe, and it also addresses a small word array included in the block. That array has a read path that a mode pin sets to flow-through or pipelined. The reload register holds the most recent strobe-loaded address. A burst can return to that address in the cycle the reload input is asserted, with no idle cycle between.

Top module: `burst_addr_port`

## Requirements
- R1: With the reload input high and the strobe low, the access address in that cycle equals the external address.
- R2: With reload and strobe high and the step enable low, the access address is the previous access address plus one, and this cycle's access goes to the stepped address.
- R3: With reload, strobe and step enable all high, the access address equals the previous cycle's access address.
- R4: With the reload input low, the access address equals the last address loaded by the strobe, with no idle cycle. A later step continues from that address.
- R5: Priority is reload, then strobe, then step. The reload register changes only on a strobe load made while reload is high, and never on a step.
- R6: Stepping from an all-ones offset gives offset zero in the next bank. The address is bank in the upper BANK_W bits and offset in the lower OFS_W bits.
- R7: Stepping from the all-ones address (last bank, last offset) gives address zero.
- R8: After reset the counter and the reload register are zero. An idle cycle or a reload cycle therefore accesses address zero.
- R9: When wr_en is high, wdata is written to the array word indexed by the low MEM_IDX_W bits of the access address.
- R10: With pipe_sel low, the data read in a cycle appears on rdata after the next clock edge. With pipe_sel high it appears one edge later.
- R11: Read data for a write cycle is the data being written in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_sel | input | 1 | 0 = flow-through read, 1 = pipelined read |
| ext_addr | input | BANK_W+OFS_W | External address, {bank, offset} |
| ld_n | input | 1 | Active-low address strobe |
| step_n | input | 1 | Active-low counter step enable |
| reload_n | input | 1 | Active-low reload of the last strobe-loaded address |
| wr_en | input | 1 | Write this cycle's access |
| wdata | input | DATA_W | Write data |
| acc_addr | output | BANK_W+OFS_W | Access address chosen for this cycle |
| acc_we | output | 1 | Write strobe to the array |
| rdata | output | DATA_W | Read data |

## Verification
The hardest cases to reach are the bank carries, because a counter that starts at zero would have to step about a quarter of a million times before it crosses the last bank. The stimulus avoids this by loading addresses just below a bank edge and just below the all-ones address, and then stepping across them. The other hard case is the rule that the reload register ignores a strobe given together with reload. The stimulus asserts both at once with a new address, then reloads alone and steps, so that the stale reload value becomes visible on the address outputs.

// File: rtl/burst_pkg.sv
// Package: types shared by the burst address sequencer.
package burst_pkg;
    // Address source chosen for the current cycle.
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_STEP   = 2'd1,
        SRC_LOAD   = 2'd2,
        SRC_RELOAD = 2'd3
    } addr_src_e;
endpackage

// File: rtl/bap_src_sel.sv
// Module: bap_src_sel
// Resolves the three active-low controls into one address source.
// Assumes: reload outranks the strobe, and the strobe outranks step.
module bap_src_sel
    import burst_pkg::*;
(
    input  logic      ld_n,
    input  logic      step_n,
    input  logic      reload_n,
    output addr_src_e src
);
    // Priority decode of the controls.
    always_comb begin
        if (!reload_n)    src = SRC_RELOAD;
        else if (!ld_n)   src = SRC_LOAD;
        else if (!step_n) src = SRC_STEP;
        else              src = SRC_HOLD;
    end
endmodule

// File: rtl/bap_addr_gen.sv
// Module: bap_addr_gen
// Keeps the burst counter ({bank, offset}) and the reload register, and
// forms this cycle's access address from the chosen source.
// Assumes: synchronous active-low reset; the offset carries into the bank
// and the bank wraps modulo 2**BANK_W.
module bap_addr_gen
    import burst_pkg::*;
#(
    parameter int BANK_W = 6,
    parameter int OFS_W  = 12,
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  addr_src_e         src,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr
);
    logic [BANK_W-1:0] bank_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [ADDR_W-1:0] saved_q;
    logic [OFS_W-1:0]  ofs_inc;
    logic [BANK_W-1:0] bank_inc;
    logic              ofs_carry;

    // Step the offset field and pass its carry into the bank field.
    always_comb begin
        ofs_inc   = ofs_q + OFS_W'(1);
        ofs_carry = &ofs_q;
        bank_inc  = bank_q + BANK_W'(ofs_carry);
    end

    // Choose the access address for this cycle.
    always_comb begin
        unique case (src)
            SRC_RELOAD: addr = saved_q;
            SRC_LOAD:   addr = ext_addr;
            SRC_STEP:   addr = {bank_inc, ofs_inc};
            default:    addr = {bank_q, ofs_q};
        endcase
    end

    // The counter follows every access so that bursts continue from it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
            ofs_q  <= '0;
        end else begin
            bank_q <= addr[ADDR_W-1:OFS_W];
            ofs_q  <= addr[OFS_W-1:0];
        end
    end

    // Only a strobe load updates the reload register.
    always_ff @(posedge clk) begin
        if (!rst_n)               saved_q <= '0;
        else if (src == SRC_LOAD) saved_q <= ext_addr;
    end
endmodule

// File: rtl/bap_word_array.sv
// Module: bap_word_array
// Small single-port word array with a registered read and an optional
// second output stage chosen at run time.
// Assumes: pipe_sel changes only between bursts; a write cycle reads back
// the written data.
module bap_word_array #(
    parameter int DATA_W    = 18,
    parameter int IDX_W     = 8,
    localparam int DEPTH    = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] pipe_q;

    // Store write data.
    always_ff @(posedge clk) begin
        if (we) words[idx] <= wdata;
    end

    // First read stage; a write passes its data straight through.
    always_ff @(posedge clk) begin
        if (!rst_n)  rd_q <= '0;
        else if (we) rd_q <= wdata;
        else         rd_q <= words[idx];
    end

    // Second read stage, used in pipelined mode.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= rd_q;
    end

    // Select the output stage for the mode.
    always_comb rdata = pipe_sel ? pipe_q : rd_q;
endmodule

// File: rtl/burst_addr_port.sv
// Module: burst_addr_port (top)
// One memory port: the address sequencer plus a small array that it addresses.
// Assumes: the array is indexed by the low MEM_IDX_W bits of the address.
module burst_addr_port
    import burst_pkg::*;
#(
    parameter int BANK_W    = 6,
    parameter int OFS_W     = 12,
    parameter int DATA_W    = 18,
    parameter int MEM_IDX_W = 8,
    localparam int ADDR_W   = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              ld_n,
    input  logic              step_n,
    input  logic              reload_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_we,
    output logic [DATA_W-1:0] rdata
);
    addr_src_e src;

    bap_src_sel u_sel (
        .ld_n     (ld_n),
        .step_n   (step_n),
        .reload_n (reload_n),
        .src      (src)
    );

    bap_addr_gen #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .ext_addr (ext_addr),
        .addr     (acc_addr)
    );

    // The write strobe goes with the access address of the same cycle.
    always_comb acc_we = wr_en;

    bap_word_array #(.DATA_W(DATA_W), .IDX_W(MEM_IDX_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pipe_sel (pipe_sel),
        .idx      (acc_addr[MEM_IDX_W-1:0]),
        .we       (acc_we),
        .wdata    (wdata),
        .rdata    (rdata)
    );
endmodule

// File: rtl/burst_addr_port_chk.sv
// Module: burst_addr_port_chk
// Port-level properties of the address sequencer, bound into the top.
// Assumes: the same parameters as the top it is bound to.
module burst_addr_port_chk #(
    parameter int BANK_W = 6,
    parameter int OFS_W  = 12,
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ld_n,
    input logic              step_n,
    input logic              reload_n,
    input logic [ADDR_W-1:0] acc_addr
);
    logic              live_q;
    logic [ADDR_W-1:0] last_ld_q;

    // Marks cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // Records the last strobe load observed at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_ld_q <= '0;
        else if (reload_n && !ld_n) last_ld_q <= ext_addr;
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_n && !ld_n) |-> (acc_addr == ext_addr));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && reload_n && ld_n && !step_n) |->
            (acc_addr == ADDR_W'($past(acc_addr) + 1'b1)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && reload_n && ld_n && step_n) |-> (acc_addr == $past(acc_addr)));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_n) |-> (acc_addr == last_ld_q));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && reload_n && ld_n && !step_n && ($past(acc_addr) == '1)) |->
            (acc_addr == '0));
endmodule

bind burst_addr_port burst_addr_port_chk #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .ld_n     (ld_n),
    .step_n   (step_n),
    .reload_n (reload_n),
    .acc_addr (acc_addr)
);

// File: tb/sim_burst_addr_port.sv
module sim_burst_addr_port;
    localparam int BW = 6, OW = 12, DW = 18, IW = 8;
    localparam int AW = BW + OW;
    localparam int AMASK = (1 << AW) - 1;
    localparam int OMASK = (1 << OW) - 1;
    localparam int DEPTH = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pipe_sel = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic ld_n = 1'b1, step_n = 1'b1, reload_n = 1'b1, wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] acc_addr;
    logic acc_we;
    logic [DW-1:0] rdata;

    always #4 clk = ~clk;

    burst_addr_port #(.BANK_W(BW), .OFS_W(OW), .DATA_W(DW), .MEM_IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel), .ext_addr(ext_addr),
        .ld_n(ld_n), .step_n(step_n), .reload_n(reload_n), .wr_en(wr_en),
        .wdata(wdata), .acc_addr(acc_addr), .acc_we(acc_we), .rdata(rdata)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int cnt_m = 0, saved_m = 0;
    int mem_m [DEPTH];
    bit mem_v [DEPTH];
    int h1_val, h2_val;
    bit h1_ok = 0, h2_ok = 0;
    string h1_tag = "R10", h2_tag = "R10";
    bit first = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive, compare address, then advance the reference model.
    task automatic cyc(bit ld, bit st, bit rl, bit we, int a, int d);
        int exp_a, idx;
        string tag;
        @(negedge clk);
        if (pipe_sel ? h2_ok : h1_ok)
            chk(pipe_sel ? h2_tag : h1_tag, int'(rdata), pipe_sel ? h2_val : h1_val);
        ld_n = ld; step_n = st; reload_n = rl; wr_en = we;
        ext_addr = AW'(a); wdata = DW'(d);
        #1;
        if (!rl) begin exp_a = saved_m; tag = ld ? "R4" : "R5"; end
        else if (!ld) begin exp_a = a & AMASK; tag = st ? "R1" : "R5"; end
        else if (!st) begin
            exp_a = (cnt_m + 1) & AMASK;
            tag = (cnt_m == AMASK) ? "R7" : ((cnt_m & OMASK) == OMASK) ? "R6" : "R2";
        end else begin exp_a = cnt_m; tag = "R3"; end
        if (first) tag = "R8";
        first = 0;
        chk(tag, int'(acc_addr), exp_a);
        chk("R9", int'(acc_we), int'(we));
        if (rl && !ld) saved_m = a & AMASK;
        cnt_m = exp_a;
        idx = exp_a % DEPTH;
        h2_val = h1_val; h2_ok = h1_ok; h2_tag = h1_tag;
        if (we) begin
            mem_m[idx] = d & ((1 << DW) - 1); mem_v[idx] = 1;
            h1_val = mem_m[idx]; h1_ok = 1; h1_tag = "R11";
        end else begin
            h1_val = mem_m[idx]; h1_ok = mem_v[idx]; h1_tag = "R10";
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_v[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        first = 1;
        cyc(1, 1, 1, 0, 0, 0);             // R8 idle after reset
        cyc(1, 1, 0, 0, 0, 0);             // R8 reload after reset gives zero
        // R9: fill the array by a write burst from a strobe load
        cyc(0, 1, 1, 1, 0, 'h100);
        for (int i = 1; i < DEPTH; i++) cyc(1, 0, 1, 1, 0, 'h100 + i * 7);
        // R10 flow-through: load, step, step, hold, reload, step
        cyc(0, 1, 1, 0, 'h0005, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 1, 1, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 1, 1, 0, 0, 0);
        // R10 pipelined: same pattern one edge later
        @(negedge clk); pipe_sel = 1'b1;
        h1_ok = 0; h2_ok = 0;
        cyc(0, 1, 1, 0, 'h1033, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 1, 1, 0, 0, 0);
        cyc(1, 1, 1, 0, 0, 0);
        @(negedge clk); pipe_sel = 1'b0;
        h1_ok = 0; h2_ok = 0;
        // R5: reload together with a strobe keeps the old reload value
        cyc(0, 1, 1, 0, 'h2222, 0);
        cyc(0, 0, 0, 0, 'h3ABC, 0);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 'h0777, 0);        // strobe outranks step
        cyc(1, 0, 0, 0, 0, 0);             // reload outranks step
        // R6: offset carry into the next bank
        cyc(0, 1, 1, 0, (2 << OW) | 'hFFE, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        // R7: last bank wraps to bank zero
        cyc(0, 1, 1, 0, AMASK - 1, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        // R11 and R9: write burst with a held cycle, then read back
        cyc(0, 1, 1, 1, 'h0040, 'h3AAAA);
        cyc(1, 0, 1, 1, 0, 'h15555);
        cyc(1, 1, 1, 1, 0, 'h0BEEF);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 1, 1, 0, 0, 0);
        cyc(1, 1, 1, 0, 0, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule